// File: doc/BRIEF.md
# Address Range Access Checker

This block sits on a memory-mapped request path and decides, request by request, whether an access may reach the target. It keeps a small table of address windows. Each window has a lower and an upper bound, an enable, separate read, write and fetch permissions, and two role masks: one for reads and fetches, one for writes. An incoming request carries an address, an access kind and a role vector. The block forwards a permitted request downstream in the same cycle and registers a response one cycle later. A refused request is not forwarded. It gets an error response with zero data, advances a saturating refusal counter, and overwrites a record of the most recent refusal.

A configuration write port loads the window fields, a global counter threshold and a per-window lock. Once a window is locked, its fields, including the lock itself, can no longer be changed. An 8-bit bypass input with a multi-bit encoding can switch checking off. Only its single exact "true" code does so.

Top module: `arc_access_gate`

## Requirements
- R1: A window matches an address when lower <= address < upper (field codes 0 and 1). A window whose upper bound is not greater than its lower bound never matches.
- R2: A request that matches no enabled window is refused: fwd_valid_o stays low and the response carries rsp_err_o=1 and rsp_rdata_o=0. A window whose enable bit is clear never matches.
- R3: The permission field (code 2) holds read in bit 0, write in bit 1, fetch in bit 2 and enable in bit 3. Access kinds are encoded 0 for read, 1 for write and 2 for fetch. Kind 3 is always refused.
- R4: The policy field (code 3) holds the read/fetch role mask in bits 15:0 and the write role mask in bits 31:16. The role check passes when the relevant mask and the request roles share at least one set bit.
- R5: When windows overlap, the enabled matching window with the lowest index alone decides the outcome.
- R6: A permitted request raises fwd_valid_o in the same cycle. On the next cycle rsp_valid_o=1 and rsp_err_o=0, and rsp_rdata_o carries fwd_rdata_i for reads and fetches and zero for writes.
- R7: The lock field (code 4) is written with a 4-bit value. 4'h6 leaves the window open; any other value locks it. After locking, writes to that window's bounds, permissions, policy and lock are ignored.
- R8: While bypass_i equals 8'h96, every request is permitted and the refusal counter holds. Any other value keeps checking active.
- R9: Each refused request increments deny_cnt_o by one. The counter saturates at its all-ones value.
- R10: deny_irq_o is high whenever the threshold (field code 5) is non-zero and deny_cnt_o >= threshold.
- R11: On each refusal, the log outputs record the deciding window index, a no-match flag, the access kind, and whether the role check was the cause. The log then holds until the next refusal.
- R12: After reset, the counter, interrupt and response valid are low, every window is disabled and unlocked, and the threshold is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Window index for the write |
| cfg_field_i | input | 3 | Field code 0..5 |
| cfg_wdata_i | input | 32 | Configuration data |
| bypass_i | input | 8 | Multi-bit bypass, 8'h96 = bypass |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | AW | Request address |
| req_type_i | input | 2 | Access kind |
| req_roles_i | input | ROLE_W | Request role vector |
| req_wdata_i | input | 32 | Write data |
| fwd_valid_o | output | 1 | Forwarded request valid |
| fwd_addr_o | output | AW | Forwarded address |
| fwd_type_o | output | 2 | Forwarded access kind |
| fwd_wdata_o | output | 32 | Forwarded write data |
| fwd_rdata_i | input | 32 | Downstream read data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_err_o | output | 1 | Response error |
| rsp_rdata_o | output | 32 | Response data |
| deny_cnt_o | output | CNT_W | Refusal counter |
| deny_irq_o | output | 1 | Threshold interrupt |
| log_idx_o | output | IDX_W | Deciding window of last refusal |
| log_nomatch_o | output | 1 | Last refusal hit no window |
| log_type_o | output | 2 | Kind of last refusal |
| log_role_fail_o | output | 1 | Last refusal failed the role check |

## Verification
The bench builds the block with four windows and a 3-bit counter. Four windows are enough to configure an overlapping pair, a zero-width window and a disabled window together. The small counter lets the bench reach both the interrupt threshold and counter saturation within a few dozen requests.

// File: rtl/arc_pkg.sv
package arc_pkg;

  // access kind carried by a request
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // configuration field selector
  typedef enum logic [2:0] {
    FLD_LOWER  = 3'd0,
    FLD_UPPER  = 3'd1,
    FLD_PERM   = 3'd2,
    FLD_POLICY = 3'd3,
    FLD_LOCK   = 3'd4,
    FLD_THRESH = 3'd5
  } cfg_field_e;

  // permission bit positions
  localparam int unsigned PB_READ  = 0;
  localparam int unsigned PB_WRITE = 1;
  localparam int unsigned PB_EXEC  = 2;
  localparam int unsigned PB_EN    = 3;

  localparam logic [3:0] MB4_TRUE = 4'h6;
  localparam logic [7:0] MB8_TRUE = 8'h96;

endpackage

// File: rtl/arc_range_entry.sv
module arc_range_entry
  import arc_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned ROLE_W = 16,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned IDX    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [2:0]        cfg_field_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  input  logic [AW-1:0]     addr_i,
  output logic              hit_o,
  output logic [2:0]        rwx_o,
  output logic [ROLE_W-1:0] rd_mask_o,
  output logic [ROLE_W-1:0] wr_mask_o
);

  logic [AW-1:0]     lower_q, lower_d;
  logic [AW-1:0]     upper_q, upper_d;
  logic [3:0]        perm_q, perm_d;
  logic [ROLE_W-1:0] rdm_q, rdm_d;
  logic [ROLE_W-1:0] wrm_q, wrm_d;
  logic [3:0]        lock_q, lock_d;
  logic              sel_me, open_win, upd;

  assign sel_me   = cfg_we_i && (cfg_idx_i == IDX_W'(IDX));
  // only the exact open code keeps the window writable
  assign open_win = (lock_q == MB4_TRUE);
  assign upd      = sel_me && open_win;

  always_comb begin
    lower_d = lower_q;
    upper_d = upper_q;
    perm_d  = perm_q;
    rdm_d   = rdm_q;
    wrm_d   = wrm_q;
    lock_d  = lock_q;
    if (upd) begin
      case (cfg_field_i)
        FLD_LOWER:  lower_d = cfg_wdata_i[AW-1:0];
        FLD_UPPER:  upper_d = cfg_wdata_i[AW-1:0];
        FLD_PERM:   perm_d  = cfg_wdata_i[3:0];
        FLD_POLICY: begin
          rdm_d = cfg_wdata_i[ROLE_W-1:0];
          wrm_d = cfg_wdata_i[2*ROLE_W-1:ROLE_W];
        end
        FLD_LOCK:   lock_d  = cfg_wdata_i[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lower_q <= '0;
      upper_q <= '0;
      perm_q  <= '0;
      rdm_q   <= '0;
      wrm_q   <= '0;
      lock_q  <= MB4_TRUE;
    end else if (upd) begin
      lower_q <= lower_d;
      upper_q <= upper_d;
      perm_q  <= perm_d;
      rdm_q   <= rdm_d;
      wrm_q   <= wrm_d;
      lock_q  <= lock_d;
    end
  end

  // half-open window; an empty or inverted window can never hit
  assign hit_o     = perm_q[PB_EN] && (addr_i >= lower_q) && (addr_i < upper_q);
  assign rwx_o     = perm_q[2:0];
  assign rd_mask_o = rdm_q;
  assign wr_mask_o = wrm_q;

endmodule

// File: rtl/arc_decide.sv
module arc_decide
  import arc_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned ROLE_W = 16,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [N-1:0]             hit_i,
  input  logic [N-1:0][2:0]        rwx_i,
  input  logic [N-1:0][ROLE_W-1:0] rd_mask_i,
  input  logic [N-1:0][ROLE_W-1:0] wr_mask_i,
  input  logic [1:0]               kind_i,
  input  logic [ROLE_W-1:0]        roles_i,
  input  logic                     bypass_on_i,
  output logic                     allow_o,
  output logic [IDX_W-1:0]         sel_o,
  output logic                     nomatch_o,
  output logic                     role_fail_o
);

  logic              found;
  logic [IDX_W-1:0]  sel;
  logic [2:0]        rwx;
  logic [ROLE_W-1:0] mask;
  logic              kind_ok, role_ok;

  // lowest index wins: scan downwards so the last assignment is the lowest hit
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    rwx = rwx_i[sel];
    case (kind_i)
      ACC_READ:  begin kind_ok = rwx[PB_READ];  mask = rd_mask_i[sel]; end
      ACC_WRITE: begin kind_ok = rwx[PB_WRITE]; mask = wr_mask_i[sel]; end
      ACC_FETCH: begin kind_ok = rwx[PB_EXEC];  mask = rd_mask_i[sel]; end
      default:   begin kind_ok = 1'b0;          mask = '0;             end
    endcase
    role_ok = |(mask & roles_i);
  end

  assign allow_o     = bypass_on_i || (found && kind_ok && role_ok);
  assign sel_o       = sel;
  assign nomatch_o   = !found;
  assign role_fail_o = found && kind_ok && !role_ok;

endmodule

// File: rtl/arc_deny_track.sv
module arc_deny_track #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             deny_i,
  input  logic [IDX_W-1:0] sel_i,
  input  logic             nomatch_i,
  input  logic             role_fail_i,
  input  logic [1:0]       kind_i,
  input  logic             thr_we_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic [IDX_W-1:0] log_idx_o,
  output logic             log_nomatch_o,
  output logic [1:0]       log_kind_o,
  output logic             log_role_fail_o
);

  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, thr_q;
  logic             cnt_en;
  logic [IDX_W-1:0] lidx_q;
  logic             lnm_q, lrf_q;
  logic [1:0]       lkind_q;

  assign cnt_en = deny_i && (cnt_q != CntMax);
  assign cnt_d  = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       thr_q <= '0;
    else if (thr_we_i) thr_q <= thr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lidx_q  <= '0;
      lnm_q   <= 1'b0;
      lrf_q   <= 1'b0;
      lkind_q <= 2'd0;
    end else if (deny_i) begin
      lidx_q  <= sel_i;
      lnm_q   <= nomatch_i;
      lrf_q   <= role_fail_i;
      lkind_q <= kind_i;
    end
  end

  assign cnt_o           = cnt_q;
  assign irq_o           = (thr_q != '0) && (cnt_q >= thr_q);
  assign log_idx_o       = lidx_q;
  assign log_nomatch_o   = lnm_q;
  assign log_kind_o      = lkind_q;
  assign log_role_fail_o = lrf_q;

endmodule

// File: rtl/arc_access_gate.sv
module arc_access_gate
  import arc_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned AW     = 32,
  parameter int unsigned ROLE_W = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [2:0]        cfg_field_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [7:0]        bypass_i,
  input  logic              req_valid_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [1:0]        req_type_i,
  input  logic [ROLE_W-1:0] req_roles_i,
  input  logic [31:0]       req_wdata_i,
  output logic              fwd_valid_o,
  output logic [AW-1:0]     fwd_addr_o,
  output logic [1:0]        fwd_type_o,
  output logic [31:0]       fwd_wdata_o,
  input  logic [31:0]       fwd_rdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [31:0]       rsp_rdata_o,
  output logic [CNT_W-1:0]  deny_cnt_o,
  output logic              deny_irq_o,
  output logic [IDX_W-1:0]  log_idx_o,
  output logic              log_nomatch_o,
  output logic [1:0]        log_type_o,
  output logic              log_role_fail_o
);

  logic [N-1:0]             hit;
  logic [N-1:0][2:0]        rwx;
  logic [N-1:0][ROLE_W-1:0] rdm, wrm;
  logic                     bypass_on, allow, nomatch, role_fail, deny;
  logic [IDX_W-1:0]         sel;
  logic                     rsp_valid_q, rsp_err_q, rsp_err_d;
  logic [31:0]              rsp_rdata_q, rsp_rdata_d;

  for (genvar g = 0; g < N; g++) begin : g_win
    arc_range_entry #(
      .AW(AW), .DW(32), .ROLE_W(ROLE_W), .IDX_W(IDX_W), .IDX(g)
    ) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i),
      .cfg_idx_i  (cfg_idx_i),
      .cfg_field_i(cfg_field_i),
      .cfg_wdata_i(cfg_wdata_i),
      .addr_i     (req_addr_i),
      .hit_o      (hit[g]),
      .rwx_o      (rwx[g]),
      .rd_mask_o  (rdm[g]),
      .wr_mask_o  (wrm[g])
    );
  end

  assign bypass_on = (bypass_i == MB8_TRUE);

  arc_decide #(.N(N), .ROLE_W(ROLE_W), .IDX_W(IDX_W)) u_decide (
    .hit_i      (hit),
    .rwx_i      (rwx),
    .rd_mask_i  (rdm),
    .wr_mask_i  (wrm),
    .kind_i     (req_type_i),
    .roles_i    (req_roles_i),
    .bypass_on_i(bypass_on),
    .allow_o    (allow),
    .sel_o      (sel),
    .nomatch_o  (nomatch),
    .role_fail_o(role_fail)
  );

  assign deny = req_valid_i && !allow;

  arc_deny_track #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_track (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .deny_i         (deny),
    .sel_i          (sel),
    .nomatch_i      (nomatch),
    .role_fail_i    (role_fail),
    .kind_i         (req_type_i),
    .thr_we_i       (cfg_we_i && (cfg_field_i == FLD_THRESH)),
    .thr_i          (cfg_wdata_i[CNT_W-1:0]),
    .cnt_o          (deny_cnt_o),
    .irq_o          (deny_irq_o),
    .log_idx_o      (log_idx_o),
    .log_nomatch_o  (log_nomatch_o),
    .log_kind_o     (log_type_o),
    .log_role_fail_o(log_role_fail_o)
  );

  assign fwd_valid_o = req_valid_i && allow;
  assign fwd_addr_o  = req_addr_i;
  assign fwd_type_o  = req_type_i;
  assign fwd_wdata_o = req_wdata_i;

  always_comb begin
    rsp_err_d   = !allow;
    rsp_rdata_d = '0;
    if (allow && (req_type_i != ACC_WRITE)) rsp_rdata_d = fwd_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_valid_q <= 1'b0;
    else         rsp_valid_q <= req_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (req_valid_i) begin
      rsp_err_q   <= rsp_err_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rsp_rdata_q;

endmodule

// File: rtl/arc_access_gate_sva.sv
module arc_access_gate_sva #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [7:0]       bypass_i,
  input logic             fwd_valid_o,
  input logic             rsp_valid_o,
  input logic             rsp_err_o,
  input logic [31:0]      rsp_rdata_o,
  input logic [CNT_W-1:0] deny_cnt_o
);

  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  p_rsp_follows_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_no_rsp_without_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  p_fwd_ok_rsp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |=> (rsp_valid_o && !rsp_err_o));

  p_refuse_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !fwd_valid_o) |=> rsp_err_o);

  p_err_zero_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == 32'd0));

  p_bypass_holds_cnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_i == 8'h96) |=> $stable(deny_cnt_o));

  p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ((deny_cnt_o == $past(deny_cnt_o)) ||
         (deny_cnt_o == CNT_W'($past(deny_cnt_o) + CNT_W'(1)))));

  p_cnt_on_refusal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !fwd_valid_o && (deny_cnt_o != CntMax)) |=>
      (deny_cnt_o == CNT_W'($past(deny_cnt_o) + CNT_W'(1))));

endmodule

bind arc_access_gate arc_access_gate_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .bypass_i   (bypass_i),
  .fwd_valid_o(fwd_valid_o),
  .rsp_valid_o(rsp_valid_o),
  .rsp_err_o  (rsp_err_o),
  .rsp_rdata_o(rsp_rdata_o),
  .deny_cnt_o (deny_cnt_o)
);

// File: tb/arc_access_gate_bench.sv
`timescale 1ns/1ps
module arc_access_gate_bench;

  localparam int unsigned N     = 4;
  localparam int unsigned AW    = 32;
  localparam int unsigned RW    = 16;
  localparam int unsigned CW    = 3;
  localparam int unsigned IW    = 2;
  localparam logic [31:0] MIXK  = 32'h5A5A_0F0F;

  logic          clk, rst_n;
  logic          cfg_we;
  logic [IW-1:0] cfg_idx;
  logic [2:0]    cfg_field;
  logic [31:0]   cfg_wdata;
  logic [7:0]    bypass;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_type;
  logic [RW-1:0] req_roles;
  logic [31:0]   req_wdata;
  logic          fwd_valid;
  logic [AW-1:0] fwd_addr;
  logic [1:0]    fwd_type;
  logic [31:0]   fwd_wdata, fwd_rdata;
  logic          rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;
  logic [CW-1:0] deny_cnt;
  logic          deny_irq;
  logic [IW-1:0] log_idx;
  logic          log_nomatch, log_role_fail;
  logic [1:0]    log_type;

  arc_access_gate #(.N(N), .AW(AW), .ROLE_W(RW), .CNT_W(CW)) u_arc_access_gate (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_field_i(cfg_field), .cfg_wdata_i(cfg_wdata),
    .bypass_i(bypass),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_type_i(req_type),
    .req_roles_i(req_roles), .req_wdata_i(req_wdata),
    .fwd_valid_o(fwd_valid), .fwd_addr_o(fwd_addr), .fwd_type_o(fwd_type),
    .fwd_wdata_o(fwd_wdata), .fwd_rdata_i(fwd_rdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .deny_cnt_o(deny_cnt), .deny_irq_o(deny_irq),
    .log_idx_o(log_idx), .log_nomatch_o(log_nomatch), .log_type_o(log_type),
    .log_role_fail_o(log_role_fail)
  );

  // downstream target: data derived from the address
  assign fwd_rdata = fwd_addr ^ MIXK;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk, n_err;
  bit done;
  int exp_cnt, exp_thr;
  bit byp_on;

  typedef struct { bit err; logic [31:0] data; string tag; } exp_t;
  exp_t sbq[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares each response against the queued expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R6 unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(rsp_err == e.err, {e.tag, " rsp_err"}, 32'(rsp_err), 32'(e.err));
        check(rsp_rdata == e.data, {e.tag, " rsp_rdata"}, rsp_rdata, e.data);
      end
    end
  end

  task automatic cfg(input int idx, input logic [2:0] fld, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_field = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_req(input logic [31:0] a, input logic [1:0] ty, input logic [15:0] roles,
                        input bit allow, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_type = ty; req_roles = roles;
    req_wdata = a + 32'h11;
    e.err  = !allow;
    e.data = (allow && ty != 2'd1) ? (a ^ MIXK) : 32'd0;
    e.tag  = tag;
    sbq.push_back(e);
    #1;
    check(fwd_valid == allow, {tag, " fwd_valid"}, 32'(fwd_valid), 32'(allow));
    if (allow) check(fwd_addr == a, {tag, " fwd_addr"}, fwd_addr, a);
    @(negedge clk);
    req_valid = 1'b0;
    if (!allow && !byp_on && exp_cnt < 7) exp_cnt++;
    check(deny_cnt == CW'(exp_cnt), {tag, " R9 deny_cnt"}, 32'(deny_cnt), 32'(exp_cnt));
    check(deny_irq == (exp_thr != 0 && exp_cnt >= exp_thr), {tag, " R10 irq"},
          32'(deny_irq), 32'(exp_thr != 0 && exp_cnt >= exp_thr));
  endtask

  task automatic chk_log(input int idx, input bit nm, input logic [1:0] ty, input bit rf, input string tag);
    if (!nm) check(log_idx == IW'(idx), {tag, " R11 log_idx"}, 32'(log_idx), 32'(idx));
    check(log_nomatch == nm, {tag, " R11 log_nomatch"}, 32'(log_nomatch), 32'(nm));
    check(log_type == ty, {tag, " R11 log_type"}, 32'(log_type), 32'(ty));
    check(log_role_fail == rf, {tag, " R11 log_role_fail"}, 32'(log_role_fail), 32'(rf));
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 0; exp_cnt = 0; exp_thr = 0; byp_on = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_field = '0; cfg_wdata = '0;
    bypass = 8'h69; req_valid = 1'b0; req_addr = '0; req_type = '0; req_roles = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(deny_cnt == '0, "R12 deny_cnt", 32'(deny_cnt), 0);
    check(!deny_irq, "R12 irq", 32'(deny_irq), 0);
    check(!rsp_valid, "R12 rsp_valid", 32'(rsp_valid), 0);
    check(!fwd_valid, "R12 fwd_valid", 32'(fwd_valid), 0);
    do_req(32'h1000, 2'd0, 16'h0001, 0, "R12 empty table");
    chk_log(0, 1, 2'd0, 0, "R12");

    // window 0: [0x1000,0x2000) rw, masks open; window 1: [0x1800,0x3000) rwx, masks 1/2
    cfg(0, 3'd0, 32'h1000); cfg(0, 3'd1, 32'h2000); cfg(0, 3'd2, 32'hB); cfg(0, 3'd3, 32'hFFFF_FFFF);
    cfg(1, 3'd0, 32'h1800); cfg(1, 3'd1, 32'h3000); cfg(1, 3'd2, 32'hF); cfg(1, 3'd3, 32'h0002_0001);
    cfg(2, 3'd0, 32'h5000); cfg(2, 3'd1, 32'h5000); cfg(2, 3'd2, 32'hF); cfg(2, 3'd3, 32'hFFFF_FFFF);
    cfg(3, 3'd0, 32'h6000); cfg(3, 3'd1, 32'h7000); cfg(3, 3'd2, 32'h7); cfg(3, 3'd3, 32'hFFFF_FFFF);

    do_req(32'h1000, 2'd0, 16'h0001, 1, "R1 lower edge");
    do_req(32'h1FFF, 2'd0, 16'h0001, 1, "R1 top inside");
    do_req(32'h2000, 2'd0, 16'h0001, 1, "R1 upper excluded, next window");
    do_req(32'h0FFF, 2'd0, 16'h0001, 0, "R2 below all");
    cfg(0, 3'd5, 32'd4); exp_thr = 4;
    do_req(32'h1800, 2'd2, 16'h0001, 0, "R5 overlap lowest decides");
    chk_log(0, 0, 2'd2, 0, "R5");
    do_req(32'h2800, 2'd2, 16'h0001, 1, "R3 fetch permitted");
    do_req(32'h2800, 2'd1, 16'h0001, 0, "R4 write role miss");
    chk_log(1, 0, 2'd1, 1, "R4");
    do_req(32'h2800, 2'd1, 16'h0006, 1, "R4 write role hit");
    do_req(32'h1100, 2'd1, 16'h8000, 1, "R4 open mask write");
    do_req(32'h1100, 2'd3, 16'h0001, 0, "R3 kind 3");
    chk_log(0, 0, 2'd3, 0, "R3");

    // R8 bypass
    bypass = 8'h96; byp_on = 1;
    do_req(32'h0000, 2'd0, 16'h0001, 1, "R8 bypass read");
    do_req(32'h6800, 2'd1, 16'h0001, 1, "R8 bypass write");
    bypass = 8'h95; byp_on = 0;
    do_req(32'h0000, 2'd0, 16'h0001, 0, "R8 near code checks");
    do_req(32'h5000, 2'd0, 16'h0001, 0, "R1 empty window");
    chk_log(0, 1, 2'd0, 0, "R1");
    do_req(32'h6800, 2'd0, 16'h0001, 0, "R2 disabled window");
    do_req(32'h6800, 2'd2, 16'h0001, 0, "R9 saturate");

    // R7 lock
    cfg(0, 3'd4, 32'h6); cfg(0, 3'd1, 32'h2100);
    do_req(32'h2080, 2'd0, 16'h0004, 1, "R7 open code keeps writable");
    cfg(0, 3'd4, 32'hA); cfg(0, 3'd1, 32'h1100);
    do_req(32'h2080, 2'd0, 16'h0004, 1, "R7 upper write ignored");
    cfg(0, 3'd2, 32'h0);
    do_req(32'h1000, 2'd0, 16'h0004, 1, "R7 perm write ignored");
    cfg(0, 3'd4, 32'h6); cfg(0, 3'd1, 32'h1100);
    do_req(32'h2080, 2'd0, 16'h0004, 1, "R7 unlock ignored");
    cfg(1, 3'd3, 32'hFFFF_FFFF);
    do_req(32'h2800, 2'd0, 16'h0004, 1, "R7 other window writable");

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R6 pending responses", 32'(sbq.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule